// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block runs one complete single-master I2C transaction on top of a byte-level I2C core. It issues start, stop, ack, nack, abort and flush commands. It also loads the byte the core should shift out. The core reports back through single-cycle events: address or data acknowledged, not acknowledged, received byte valid, stop finished, arbitration lost and bus error. The bit-level SCL/SDA engine lives in that core and is not part of this block.

A transfer is launched by a one-cycle `start` pulse while the block is idle. The pulse comes with a transfer kind, an addressing width, a 10-bit address field and two lengths: `wr_len` for the bytes to send and `rd_len` for the bytes to receive. The block pulls outgoing bytes from a byte stream (`wr_byte` / `wr_take`) and pushes incoming bytes to another (`rd_byte` / `rd_put`). The outcome is held on `result` until the next accepted start. Command and stream outputs are combinational: each answers, in the same cycle, the event or state presented in that cycle.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset `busy` is 0, `result` is 0 (idle) and every command, load and stream strobe is 0. Result codes: 0 idle, 1 running, 2 done, 3 not acknowledged, 4 arbitration lost, 5 bus error, 6 usage fault.
- R2: With 7-bit addressing the header is loaded together with a start command, in the cycle after the start is accepted. The header is `{addr[7:1], dir}`, where dir is 1 for a read (kind 1) and 0 otherwise. Kind codes: 0 write, 1 read, 2 write-then-read, 3 invalid.
- R3: With 10-bit addressing the first header is `{5'b11110, addr[9:8], 1'b0}`. When that header is acknowledged, `addr[7:0]` is loaded in the same cycle, with no start command.
- R4: For a read with 10-bit addressing, the acknowledgement of the low address byte leads, one cycle later, to a start command with the header `{5'b11110, addr[9:8], 1'b1}`.
- R5: In the cycle after a written address or data byte is acknowledged, the next write byte is loaded with `tx_load` and `wr_take` together. Once `wr_len` bytes are sent, a stop command follows instead.
- R6: For a write-then-read, after the last write byte is acknowledged, the block idles one cycle. It then issues a start with the 7-bit or 10-bit read header (dir bit 1) and receives `rd_len` bytes.
- R7: On each received byte the block pulses `rd_put` with that byte. It then issues ack if two or more bytes remain, nack if exactly one remains, and stop after the last byte. When `rd_len` is 1, nack is issued in the same cycle as the final address acknowledgement.
- R8: A not-acknowledge on any address or write byte issues stop in that same cycle. The result becomes 3 once the stop has completed.
- R9: A start with kind 3, or with kind 1 or 2 and `rd_len` 0, issues no command at all and sets result 6 while staying idle.
- R10: Arbitration lost or bus error while busy ends the transfer at once, with no command in that cycle, and sets result 4 or 5. Arbitration lost wins when both occur together, and either one wins over any other event in the same cycle.
- R11: `busy` stays 1 and result stays 1 until the stop-done event. At that event the block goes idle and reports 2 for a successful transfer.
- R12: An accepted start always issues `do_flush`. It issues `do_abort` in the same cycle only when `core_busy` is 1.
- R13: A start pulse while busy has no effect, and while idle the result holds its value until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| xfer_kind | input | 2 | 0 write, 1 read, 2 write-then-read, 3 invalid |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| addr | input | 10 | Target address (7-bit mode uses bits 7:1) |
| wr_len | input | LEN_W | Number of bytes to send |
| rd_len | input | LEN_W | Number of bytes to receive |
| wr_byte | input | 8 | Head of the outgoing byte stream |
| wr_take | output | 1 | Consumes `wr_byte` |
| rd_byte | output | 8 | Received byte |
| rd_put | output | 1 | Pushes `rd_byte` to the read stream |
| core_busy | input | 1 | Core reports the bus as busy |
| core_ack | input | 1 | Last byte acknowledged |
| core_nack | input | 1 | Last byte not acknowledged |
| core_rx_valid | input | 1 | A received byte is available |
| core_rx_byte | input | 8 | The received byte |
| core_stop_done | input | 1 | Stop condition finished |
| core_arb_lost | input | 1 | Arbitration lost |
| core_bus_err | input | 1 | Misplaced start or stop seen |
| do_start | output | 1 | Start or repeated start command |
| do_stop | output | 1 | Stop command |
| do_ack | output | 1 | Acknowledge next received byte |
| do_nack | output | 1 | Not-acknowledge next received byte |
| do_abort | output | 1 | Abort the core's current activity |
| do_flush | output | 1 | Clear transmit and pending-command buffers |
| tx_byte | output | 8 | Byte to transmit |
| tx_load | output | 1 | Loads `tx_byte` into the core |
| busy | output | 1 | Transfer in progress |
| result | output | 3 | Outcome code |

## Verification
The interesting collision is an error event arriving in the same cycle as a normal protocol event. Examples are an acknowledge together with arbitration lost and bus error, or a stop-done together with a bus error. The bench drives such pairs in one cycle and requires that no command appears in that cycle. It also requires that the error code wins in the result on the following cycle, with arbitration lost ranked above bus error.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR, ST_HDR_ACK, ST_LO_ACK, ST_RHDR,
        ST_RHDR_ACK, ST_TX, ST_TX_ACK, ST_RX, ST_STOP
    } seq_st_e;

    typedef enum logic [2:0] {
        RES_IDLE = 3'd0, RES_RUN = 3'd1, RES_DONE = 3'd2, RES_NACK = 3'd3,
        RES_ARB = 3'd4, RES_BUSERR = 3'd5, RES_USAGE = 3'd6
    } seq_res_e;

    typedef enum logic [1:0] {
        KIND_WR = 2'd0, KIND_RD = 2'd1, KIND_WRRD = 2'd2, KIND_BAD = 2'd3
    } seq_kind_e;
endpackage

// File: rtl/i2c_seq_hdr.sv
module i2c_seq_hdr (
    input  logic       ten_bit,
    input  logic [1:0] addr_hi,
    input  logic [6:0] addr_7,
    input  logic       dir_rd,
    output logic [7:0] hdr
);
    localparam logic [4:0] TEN_TAG = 5'b11110;

    always_comb begin
        if (ten_bit) hdr = {TEN_TAG, addr_hi, dir_rd};
        else         hdr = {addr_7, dir_rd};
    end
endmodule

// File: rtl/i2c_seq_bytecnt.sv
module i2c_seq_bytecnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         is_zero,
    output logic         is_one
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == ONE);

    // R5 / R7: a byte is never consumed past the programmed length
    p_cnt_nowrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       xfer_kind,
    input  logic             ten_bit,
    input  logic [9:0]       addr,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [7:0]       wr_byte,
    output logic             wr_take,
    output logic [7:0]       rd_byte,
    output logic             rd_put,
    input  logic             core_busy,
    input  logic             core_ack,
    input  logic             core_nack,
    input  logic             core_rx_valid,
    input  logic [7:0]       core_rx_byte,
    input  logic             core_stop_done,
    input  logic             core_arb_lost,
    input  logic             core_bus_err,
    output logic             do_start,
    output logic             do_stop,
    output logic             do_ack,
    output logic             do_nack,
    output logic             do_abort,
    output logic             do_flush,
    output logic [7:0]       tx_byte,
    output logic             tx_load,
    output logic             busy,
    output logic [2:0]       result
);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    typedef struct packed {
        seq_st_e   st;
        seq_res_e  res;
        seq_res_e  fin;
        seq_kind_e kind;
        logic      ten;
        logic [9:0] addr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             cnt_load, cnt_dec, cnt_zero, cnt_one;
    logic [LEN_W-1:0] cnt_val, cnt;
    logic             hdr_rd;
    logic [7:0]       hdr_byte;
    logic             bad_req;
    seq_kind_e        kind_in;

    assign kind_in = seq_kind_e'(xfer_kind);
    assign bad_req = (kind_in == KIND_BAD) ||
                     ((kind_in != KIND_WR) && (rd_len == '0));

    i2c_seq_hdr u_hdr (
        .ten_bit (r_q.ten),
        .addr_hi (r_q.addr[9:8]),
        .addr_7  (r_q.addr[7:1]),
        .dir_rd  (hdr_rd),
        .hdr     (hdr_byte)
    );

    i2c_seq_bytecnt #(.W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .cnt      (cnt),
        .is_zero  (cnt_zero),
        .is_one   (cnt_one)
    );

    always_comb begin
        r_d      = r_q;
        do_start = 1'b0; do_stop = 1'b0; do_ack  = 1'b0; do_nack = 1'b0;
        do_abort = 1'b0; do_flush = 1'b0; tx_load = 1'b0; tx_byte = 8'h00;
        wr_take  = 1'b0; rd_put  = 1'b0;
        cnt_load = 1'b0; cnt_dec = 1'b0; cnt_val = wr_len;
        hdr_rd   = 1'b0;

        case (r_q.st)
            ST_IDLE: if (start) begin
                if (bad_req) begin
                    r_d.res = RES_USAGE;
                end else begin
                    r_d.st   = ST_HDR;
                    r_d.res  = RES_RUN;
                    r_d.fin  = RES_DONE;
                    r_d.kind = kind_in;
                    r_d.ten  = ten_bit;
                    r_d.addr = addr;
                    do_flush = 1'b1;
                    do_abort = core_busy;
                    cnt_load = 1'b1;
                    cnt_val  = (kind_in == KIND_RD) ? rd_len : wr_len;
                end
            end
            ST_HDR: begin
                hdr_rd   = !r_q.ten && (r_q.kind == KIND_RD);
                do_start = 1'b1;
                tx_load  = 1'b1;
                tx_byte  = hdr_byte;
                r_d.st   = ST_HDR_ACK;
            end
            ST_HDR_ACK, ST_LO_ACK, ST_RHDR_ACK, ST_TX_ACK: begin
                if (core_nack) begin
                    do_stop = 1'b1;
                    r_d.fin = RES_NACK;
                    r_d.st  = ST_STOP;
                end else if (core_ack) begin
                    if (r_q.st == ST_HDR_ACK && r_q.ten) begin
                        tx_load = 1'b1;
                        tx_byte = r_q.addr[7:0];
                        r_d.st  = ST_LO_ACK;
                    end else if (r_q.st == ST_LO_ACK) begin
                        r_d.st = (r_q.kind == KIND_RD) ? ST_RHDR : ST_TX;
                    end else if (r_q.st == ST_TX_ACK) begin
                        r_d.st = ST_TX;
                    end else if (r_q.st == ST_RHDR_ACK || r_q.kind == KIND_RD) begin
                        r_d.st  = ST_RX;
                        do_nack = cnt_one;
                    end else begin
                        r_d.st = ST_TX;
                    end
                end
            end
            ST_RHDR: begin
                hdr_rd   = 1'b1;
                do_start = 1'b1;
                tx_load  = 1'b1;
                tx_byte  = hdr_byte;
                r_d.st   = ST_RHDR_ACK;
            end
            ST_TX: begin
                if (!cnt_zero) begin
                    tx_load = 1'b1;
                    tx_byte = wr_byte;
                    wr_take = 1'b1;
                    cnt_dec = 1'b1;
                    r_d.st  = ST_TX_ACK;
                end else if (r_q.kind == KIND_WRRD) begin
                    cnt_load = 1'b1;
                    cnt_val  = rd_len;
                    r_d.st   = ST_RHDR;
                end else begin
                    do_stop = 1'b1;
                    r_d.st  = ST_STOP;
                end
            end
            ST_RX: if (core_rx_valid) begin
                rd_put  = 1'b1;
                cnt_dec = 1'b1;
                if (cnt_one) begin
                    do_stop = 1'b1;
                    r_d.st  = ST_STOP;
                end else if (cnt == TWO) begin
                    do_nack = 1'b1;
                end else begin
                    do_ack = 1'b1;
                end
            end
            ST_STOP: if (core_stop_done) begin
                r_d.st  = ST_IDLE;
                r_d.res = r_q.fin;
            end
            default: r_d.st = ST_IDLE;
        endcase

        // errors override everything else while a transfer runs
        if (r_q.st != ST_IDLE && (core_arb_lost || core_bus_err)) begin
            r_d.st   = ST_IDLE;
            r_d.res  = core_arb_lost ? RES_ARB : RES_BUSERR;
            do_start = 1'b0; do_stop = 1'b0; do_ack = 1'b0; do_nack = 1'b0;
            tx_load  = 1'b0; wr_take = 1'b0; rd_put = 1'b0;
            cnt_dec  = 1'b0; cnt_load = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, res: RES_IDLE, fin: RES_IDLE,
                     kind: KIND_WR, ten: 1'b0, addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_byte = core_rx_byte;
    assign busy    = (r_q.st != ST_IDLE);
    assign result  = r_q.res;

    // R7: at most one response command per cycle
    p_one_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_ack, do_nack, do_stop}));
    // R3: any start-with-header in 10-bit mode carries the 10-bit tag
    p_hdr_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_start && tx_load && r_q.ten) |-> (tx_byte[7:3] == 5'b11110));
    // R5: a write byte is consumed only when it is loaded
    p_take_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> tx_load);
    // R9: rejected requests leave the block idle with a usage fault
    p_usage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && bad_req) |=> (!busy && result == RES_USAGE));
    // R10: errors abort immediately, arbitration loss ranked first
    p_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (core_arb_lost || core_bus_err)) |=> !busy);
    p_arb_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && core_arb_lost) |=> (result == RES_ARB));
    // R11: without stop-done or error the transfer keeps running
    p_wait_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_stop_done && !core_arb_lost && !core_bus_err) |=> busy);
    // R13: idle without start keeps the result
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
endmodule

// File: tb/i2c_xfer_seq_tb.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb_top;
    localparam int LEN_W = 8;
    localparam logic [6:0] C_START = 7'b1000000, C_STOP = 7'b0100000,
                           C_ACK = 7'b0010000, C_NACK = 7'b0001000,
                           C_ABORT = 7'b0000100, C_FLUSH = 7'b0000010,
                           C_LOAD = 7'b0000001, C_NONE = 7'b0000000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, ten_bit = 0, core_busy = 0;
    logic [1:0] xfer_kind = 0;
    logic [9:0] addr = 0;
    logic [LEN_W-1:0] wr_len = 0, rd_len = 0;
    logic [7:0] wr_byte = 0, core_rx_byte = 0;
    logic core_ack = 0, core_nack = 0, core_rx_valid = 0;
    logic core_stop_done = 0, core_arb_lost = 0, core_bus_err = 0;
    logic wr_take, rd_put, do_start, do_stop, do_ack, do_nack;
    logic do_abort, do_flush, tx_load, busy;
    logic [7:0] rd_byte, tx_byte;
    logic [2:0] result;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    i2c_xfer_seq #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_kind(xfer_kind),
        .ten_bit(ten_bit), .addr(addr), .wr_len(wr_len), .rd_len(rd_len),
        .wr_byte(wr_byte), .wr_take(wr_take), .rd_byte(rd_byte), .rd_put(rd_put),
        .core_busy(core_busy), .core_ack(core_ack), .core_nack(core_nack),
        .core_rx_valid(core_rx_valid), .core_rx_byte(core_rx_byte),
        .core_stop_done(core_stop_done), .core_arb_lost(core_arb_lost),
        .core_bus_err(core_bus_err), .do_start(do_start), .do_stop(do_stop),
        .do_ack(do_ack), .do_nack(do_nack), .do_abort(do_abort),
        .do_flush(do_flush), .tx_byte(tx_byte), .tx_load(tx_load),
        .busy(busy), .result(result)
    );

    function automatic logic [6:0] cmdv();
        return {do_start, do_stop, do_ack, do_nack, do_abort, do_flush, tx_load};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        start = 0; core_ack = 0; core_nack = 0; core_rx_valid = 0;
        core_stop_done = 0; core_arb_lost = 0; core_bus_err = 0; core_busy = 0;
    endtask

    task automatic launch(input string tag, input int k, input bit t, input int a,
                          input int wl, input int rl, input bit cb);
        xfer_kind = 2'(k); ten_bit = t; addr = 10'(a);
        wr_len = LEN_W'(wl); rd_len = LEN_W'(rl); core_busy = cb; start = 1;
        #1 chk({tag, " R12 accept cmds"}, cmdv(), cb ? (C_FLUSH | C_ABORT) : C_FLUSH);
        tick();
    endtask

    task automatic hdr(input string tag, input int b);
        #1 chk({tag, " hdr cmds"}, cmdv(), C_START | C_LOAD);
        chk({tag, " hdr byte"}, tx_byte, b);
        tick();
    endtask

    task automatic ack(input string tag, input logic [6:0] exp);
        core_ack = 1;
        #1 chk({tag, " ack resp"}, cmdv(), exp);
        tick();
    endtask

    task automatic ack_lo(input string tag, input int b);
        core_ack = 1;
        #1 chk({tag, " R3 low byte cmds"}, cmdv(), C_LOAD);
        chk({tag, " R3 low byte"}, tx_byte, b);
        tick();
    endtask

    task automatic txb(input string tag, input int b);
        wr_byte = 8'(b);
        #1 chk({tag, " R5 load"}, {cmdv(), wr_take}, {C_LOAD, 1'b1});
        chk({tag, " R5 byte"}, tx_byte, b);
        tick();
    endtask

    task automatic rxb(input string tag, input int b, input logic [6:0] exp);
        core_rx_valid = 1; core_rx_byte = 8'(b);
        #1 chk({tag, " R7 resp"}, cmdv(), exp);
        chk({tag, " R7 put"}, {rd_put, rd_byte}, {1'b1, 8'(b)});
        tick();
    endtask

    task automatic expect_cmd(input string tag, input logic [6:0] exp);
        #1 chk(tag, cmdv(), exp);
        tick();
    endtask

    task automatic finish_x(input string tag, input int res);
        #1 chk({tag, " R11 running"}, {busy, result}, {1'b1, 3'd1});
        core_stop_done = 1;
        tick();
        #1 chk({tag, " R11 end"}, {busy, result}, {1'b0, 3'(res)});
        tick();
    endtask

    task automatic t_reset();
        #1 chk("R1 reset state", {busy, result, cmdv(), wr_take, rd_put}, 0);
        tick();
    endtask

    task automatic t_write7();
        launch("w7", 0, 0, 'h0A4, 2, 0, 0);
        hdr("w7 R2", 'hA4);
        ack("w7", C_NONE);
        txb("w7", 'h11); ack("w7", C_NONE);
        txb("w7", 'h22); ack("w7", C_NONE);
        expect_cmd("w7 R5 stop", C_STOP);
        finish_x("w7", 2);
    endtask

    task automatic t_read7();
        launch("r7", 1, 0, 'h0A4, 0, 3, 0);
        hdr("r7 R2", 'hA5);
        ack("r7", C_NONE);
        rxb("r7 b0", 'h31, C_ACK);
        rxb("r7 b1", 'h32, C_NACK);
        rxb("r7 b2", 'h33, C_STOP);
        finish_x("r7", 2);
    endtask

    task automatic t_read_one();
        launch("r1", 1, 0, 'h03C, 0, 1, 0);
        hdr("r1 R2", 'h3D);
        ack("r1 R7 single", C_NACK);
        rxb("r1", 'h5A, C_STOP);
        finish_x("r1", 2);
    endtask

    task automatic t_read10();
        launch("r10", 1, 1, 'h2B5, 0, 2, 0);
        hdr("r10 R3", 'hF4);
        ack_lo("r10", 'hB5);
        ack("r10 R4 to rstart", C_NONE);
        hdr("r10 R4", 'hF5);
        ack("r10", C_NONE);
        rxb("r10 b0", 'hC1, C_NACK);
        rxb("r10 b1", 'hC2, C_STOP);
        finish_x("r10", 2);
    endtask

    task automatic t_write10();
        launch("w10", 0, 1, 'h1C3, 1, 0, 0);
        hdr("w10 R3", 'hF2);
        ack_lo("w10", 'hC3);
        ack("w10", C_NONE);
        txb("w10", 'h77); ack("w10", C_NONE);
        expect_cmd("w10 R5 stop", C_STOP);
        finish_x("w10", 2);
    endtask

    task automatic t_wrrd();
        launch("wr", 2, 0, 'h050, 1, 1, 0);
        hdr("wr R2", 'h50);
        ack("wr", C_NONE);
        txb("wr", 'h9E); ack("wr", C_NONE);
        expect_cmd("wr R6 gap", C_NONE);
        hdr("wr R6", 'h51);
        ack("wr R7 single", C_NACK);
        rxb("wr", 'h44, C_STOP);
        finish_x("wr", 2);
    endtask

    task automatic t_nack();
        launch("na", 0, 0, 'h042, 1, 0, 0);
        hdr("na", 'h42);
        core_nack = 1;
        #1 chk("R8 addr nack stop", cmdv(), C_STOP);
        tick();
        finish_x("na R8", 3);
        launch("nd", 0, 0, 'h042, 2, 0, 0);
        hdr("nd", 'h42);
        ack("nd", C_NONE);
        txb("nd", 'h01);
        core_nack = 1;
        #1 chk("R8 data nack stop", cmdv(), C_STOP);
        tick();
        finish_x("nd R8", 3);
    endtask

    task automatic usage(input string tag, input int k, input int rl);
        xfer_kind = 2'(k); rd_len = LEN_W'(rl); wr_len = 2; start = 1; core_busy = 1;
        #1 chk({tag, " R9 no cmd"}, cmdv(), C_NONE);
        tick();
        #1 chk({tag, " R9 fault"}, {busy, result}, {1'b0, 3'd6});
        tick();
    endtask

    task automatic t_errors();
        launch("ea", 0, 0, 'h010, 1, 0, 0);
        hdr("ea", 'h10);
        core_ack = 1; core_arb_lost = 1; core_bus_err = 1;
        #1 chk("R10 arb no cmd", cmdv(), C_NONE);
        tick();
        #1 chk("R10 arb result", {busy, result}, {1'b0, 3'd4});
        tick();
        launch("eb", 0, 0, 'h010, 0, 0, 0);
        hdr("eb", 'h10);
        ack("eb", C_NONE);
        expect_cmd("eb stop", C_STOP);
        core_stop_done = 1; core_bus_err = 1;
        #1 chk("R10 buserr no cmd", cmdv(), C_NONE);
        tick();
        #1 chk("R10 buserr result", {busy, result}, {1'b0, 3'd5});
        tick();
    endtask

    task automatic t_busy_core();
        launch("bc", 0, 0, 'h020, 0, 0, 1);
        hdr("bc", 'h20);
        ack("bc", C_NONE);
        expect_cmd("bc stop", C_STOP);
        finish_x("bc R12", 2);
    endtask

    task automatic t_ignore();
        launch("ig", 0, 0, 'h066, 0, 0, 0);
        hdr("ig", 'h66);
        xfer_kind = 2'd3; start = 1;
        #1 chk("R13 start while busy no cmd", cmdv(), C_NONE);
        tick();
        #1 chk("R13 still running", {busy, result}, {1'b1, 3'd1});
        ack("ig", C_NONE);
        expect_cmd("ig stop", C_STOP);
        finish_x("ig", 2);
        core_arb_lost = 1; core_nack = 1;
        tick(); tick();
        #1 chk("R13 idle hold", {busy, result, cmdv()}, {1'b0, 3'd2, C_NONE});
        tick();
    endtask

    initial begin
        #200_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write7();
        t_read7();
        t_read_one();
        t_read10();
        t_write10();
        t_wrrd();
        t_nack();
        usage("u1", 1, 0);
        usage("u2", 2, 0);
        usage("u3", 3, 4);
        t_errors();
        t_busy_core();
        t_ignore();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule